// File: doc/BRIEF.md
# Wakeup Oscillation Stabilization Timer

The block holds the core in a waiting state after reset, and again after a wakeup, until the selected oscillator has run long enough to be stable. It counts cycles of the clock it is clocked by, which is the selected source oscillator. While it counts it holds `busy` high. When the required number of cycles has elapsed it drops `busy` and pulses `done` for one cycle, and that pulse releases the core.

The number of cycles is derived from two inputs that are sampled on a `start` strobe:
- a stabilization class, which picks the oscillator type;
- a 2-bit divider mode, which multiplies the base count by 1, 2, 4 or 8.

Software never loads the count. Deasserting reset starts a reset-class count by itself, with no strobe needed.

Top module: `wake_stab_timer`

## Requirements
- R1: When `rst_n` goes high, `busy` is already high and stays high for exactly 5412 cycles, counting the cycle in which `rst_n` rises. After that, `done` pulses.
- R2: Class codes 1 (on-chip oscillator) and 2 (ceramic resonator) give 675 shifted left by `mode` cycles, that is 675, 1350, 2700 or 5400.
- R3: Class code 3 (RC oscillator) gives 21 shifted left by `mode` cycles, that is 21, 42, 84 or 168.
- R4: Class code 4 (sub-clock) gives 675 shifted left by `mode` cycles.
- R5: Class code 0 (reset) gives 5412 cycles whatever the mode. The unused codes 5 to 7 give 675 shifted left by `mode`.
- R6: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R7: A `start` while `busy` is high restarts the count from zero with the class and mode sampled at that strobe. The aborted count produces no `done`.
- R8: Changes on `cls` and `mode` while counting, with no `start`, do not alter the length of the count.
- R9: `busy` rises in the cycle after `start` is sampled and stays high for exactly the terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected source oscillator clock |
| rst_n | input | 1 | Active-low reset; its release begins the reset-class count |
| start | input | 1 | Wakeup strobe; samples `cls` and `mode` |
| cls | input | 3 | Stabilization class code |
| mode | input | 2 | Divider mode: 0 through, 1 /2, 2 /4, 3 /8 |
| busy | output | 1 | High while counting |
| done | output | 1 | One-cycle release pulse |

## Verification
The bench covers every class code with every divider mode and measures the length of `busy` exactly. This catches a count that is off by one, a count that is not shifted, a mode that is wrongly applied to the reset class, and RC counts routed to the long base. Each run scrambles `cls` and `mode` right after the strobe, so a design that re-reads those inputs while counting would produce the wrong length. A restart in the middle of a long count must yield only the new, shorter count and no stale pulse. Each `done` must last one cycle, with `busy` already low, or the core would be released twice or while still held.

// File: rtl/wake_stab_timer.sv
module wake_stab_timer #(
  parameter int LONG_BASE   = 675,
  parameter int SHORT_BASE  = 21,
  parameter int RESET_COUNT = 5412,
  parameter int MODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cls,
  input  logic [MODE_W-1:0] mode,
  output logic              busy,
  output logic              done
);

  localparam int MAX_DIV  = LONG_BASE << ((1 << MODE_W) - 1);
  localparam int MAX_CNT  = (RESET_COUNT > MAX_DIV) ? RESET_COUNT : MAX_DIV;
  localparam int W        = $clog2(MAX_CNT + 1);
  localparam logic [2:0] CLS_RESET = 3'd0;
  localparam logic [2:0] CLS_RC    = 3'd3;

  logic [W-1:0] cnt, tgt, base, next_tgt;

  assign base     = (cls == CLS_RC) ? W'(SHORT_BASE) : W'(LONG_BASE);
  assign next_tgt = (cls == CLS_RESET) ? W'(RESET_COUNT) : (base << mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tgt  <= W'(RESET_COUNT);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      tgt  <= next_tgt;
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy && cnt == tgt - W'(1)) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else begin
      cnt  <= busy ? cnt + W'(1) : cnt;
      done <= 1'b0;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !(done && busy)); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy && cnt == '0); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> cnt < tgt); // R9
  AST_TGT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(tgt)); // R8
  AST_RESTART_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) start |=> !done); // R7

endmodule

// File: tb/wake_stab_timer_test.sv
module wake_stab_timer_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] cls = 0;
  logic [1:0] mode = 0;
  logic busy, done;
  int total = 0, bad = 0;
  int cycles = 0;

  wake_stab_timer uut (.clk(clk), .rst_n(rst_n), .start(start), .cls(cls), .mode(mode),
                       .busy(busy), .done(done));

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input string tag, input int exp);
    int n = 0;
    while (busy && !done && n < 20000) begin
      n++;
      @(negedge clk);
    end
    check({tag, " busy length"}, n, exp);
    check({tag, " done with busy low (R6)"}, int'(done && !busy), 1);
    @(negedge clk);
    check({tag, " done one cycle (R6)"}, int'(done), 0);
  endtask

  task automatic run(input logic [2:0] c, input logic [1:0] m, input int exp, input string tag);
    @(negedge clk);
    cls = c; mode = m; start = 1;
    @(negedge clk);
    start = 0;
    cls = (c == 3'd3) ? 3'd0 : 3'd3;  // R8 scramble while counting
    mode = ~m;
    check({tag, " busy after start (R9)"}, int'(busy), 1);
    measure(tag, exp);
  endtask

  function automatic int expect_len(input int c, input int m);
    if (c == 0) return 5412;
    if (c == 3) return 21 << m;
    return 675 << m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(busy), 1);
    check("R1 reset done", int'(done), 0);
    rst_n = 1;
    measure("R1 reset release", 5412);
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 4; m++) begin
        string t;
        t = $sformatf("%s cls=%0d mode=%0d",
              (c == 0 || c > 4) ? "R5" : (c == 3) ? "R3" : (c == 4) ? "R4" : "R2", c, m);
        run(3'(c), 2'(m), expect_len(c, m), t);
      end
    begin
      int seen = 0;
      @(negedge clk);
      cls = 3'd1; mode = 2'd3; start = 1;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < 100; i++) begin
        if (done) seen++;
        @(negedge clk);
      end
      check("R7 no done before restart", seen, 0);
      run(3'd3, 2'd0, 21, "R7 restart");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule